// File: doc/BRIEF.md
# USB Bulk Pipe Packet Buffer Controller

This block keeps the bookkeeping for the packet buffer of one bulk pipe inside a USB host or device controller. The storage for the pipe is split into one or two equal sides. The side capacity is set by a size field. In receive direction the USB engine fills a side with packets and the CPU or DMA drains it. In transmit direction the CPU or DMA fills a side and the USB engine sends it. The block decides the moment a side is finished: readable for the CPU in receive, or ready to go out in transmit. At that moment it raises a one-cycle ready interrupt.

Two completion policies are available. In per-packet mode a side closes after one packet. In continuous mode several packets share a side, and the side closes on the first of several conditions: the side is full, a short packet arrives, a zero-length packet arrives after data, the packet budget is used up, the buffer-valid strobe is given, or a DMA end strobe comes with the last write. The policy switch and the double-buffer switch are accepted only while the pipe is idle. An auto-clear input empties everything.

Top module: `usbp_pipe_buf`

## Requirements
- R1: The side capacity is (cfg_size+1)*64 bytes. With double buffering off, only side 0 (side index 0 on usb_side and cpu_side) is used. A received packet is refused (rx_ack low one cycle later) when the byte count of its side plus rx_len would exceed the capacity.
- R2: In per-packet receive mode, an accepted packet of any length from 0 to the capacity sets the side ready with side count equal to rx_len in the cycle after rx_valid. A packet that arrives while the target side is ready is refused and leaves that side unchanged.
- R3: In per-packet transmit mode, one byte is counted per cpu_wr. The side becomes ready on the write that brings the count to cfg_mps, or when cpu_bval is pulsed at any count, zero included. cpu_dend has no effect in this mode.
- R4: In continuous receive mode, full-size packets (rx_len equal to cfg_mps) leave the side open until the count reaches the capacity, and the side closes on that packet.
- R5: In continuous receive mode, a packet with 0 < rx_len < cfg_mps closes the side.
- R6: In continuous receive mode, a zero-length packet closes a side that holds data. Into an empty side it is acknowledged, raises neither ready nor interrupt, and does not count toward the packet budget.
- R7: In continuous receive mode with cfg_trn nonzero, the side closes on the cfg_trn-th counted packet since the last close or clear. A value of 0 disables this rule.
- R8: In continuous transmit mode, the side closes when the written count reaches the capacity, on a cpu_bval pulse, or on a write that comes with cpu_dend, whatever the count.
- R9: rdy_irq pulses in the cycle a side first shows ready. The pulse is suppressed when double buffering is on and the direction is transmit; it is still raised in receive.
- R10: A cfg_wr changes dbl_on and cont_on only when pipe_nak is high, pipe_busy is low and pipe_sel is low. Any other cfg_wr leaves both unchanged.
- R11: aclr empties both sides, clears ready and the packet count, and returns both side pointers to 0 in the next cycle.
- R12: Sides alternate. Receive: each cpu_rd takes one byte from the ready side at cpu_side. The read that takes the last byte (or a single read of a zero-byte ready side) empties it and moves cpu_side. Transmit: tx_sent empties the ready side at usb_side and moves usb_side. When the side to fill is ready, writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | SIZE_W | Side capacity code, capacity (cfg_size+1)*64 bytes |
| cfg_dir | input | 1 | 0 receive, 1 transmit |
| cfg_mps | input | LEN_W | Maximum packet size in bytes |
| cfg_trn | input | TRN_W | Packet budget per side in continuous receive, 0 off |
| cfg_wr | input | 1 | Request to load cfg_dbl_req and cfg_cont_req |
| cfg_dbl_req | input | 1 | Requested double-buffer setting |
| cfg_cont_req | input | 1 | Requested continuous-mode setting |
| pipe_nak | input | 1 | Pipe handshake state is NAK |
| pipe_busy | input | 1 | A transaction is in progress on the pipe |
| pipe_sel | input | 1 | Pipe is the current CPU access pipe |
| aclr | input | 1 | Auto-clear of the pipe buffer |
| cpu_wr | input | 1 | CPU/DMA writes one byte (transmit) |
| cpu_bval | input | 1 | Buffer-valid strobe, closes a partial side |
| cpu_dend | input | 1 | DMA end strobe, qualified by cpu_wr |
| cpu_rd | input | 1 | CPU/DMA reads one byte (receive) |
| rx_valid | input | 1 | A received packet is presented |
| rx_len | input | LEN_W | Length of the presented packet |
| tx_sent | input | 1 | USB engine has sent the ready side |
| rx_ack | output | 1 | Previous cycle's packet was accepted |
| rdy_irq | output | 1 | Ready interrupt pulse |
| side_ready | output | 2 | Ready flag per side |
| side_count0 | output | SIZE_W+7 | Byte count of side 0 |
| side_count1 | output | SIZE_W+7 | Byte count of side 1 |
| usb_side | output | 1 | Side the USB engine works on |
| cpu_side | output | 1 | Side the CPU/DMA works on |
| dbl_on | output | 1 | Double buffering in effect |
| cont_on | output | 1 | Continuous mode in effect |

## Verification
The hardest state to reach is a continuous-mode side that holds a partial load at the moment a closing event of another kind arrives. Examples are a zero-length packet after data, the packet budget running out before the side is full, or a DMA end strobe on a short write. The bench gets there by sweeping the budget, the short length and the written count over every small value. It lays down the exact number of full packets or bytes needed to reach each partial count, then fires the closing event. It expects the side to stay open one event earlier and to close with the arithmetically predicted count.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } usbp_dir_e;

   typedef struct packed {
      logic clr;
      logic fill;
      logic close;
      logic drain_one;
      logic drain_all;
   } usbp_side_ctl_s;
endpackage

// File: rtl/usbp_cfg_gate.sv
module usbp_cfg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic dbl_req,
   input  logic cont_req,
   input  logic pipe_nak,
   input  logic pipe_busy,
   input  logic pipe_sel,
   output logic dbl_q,
   output logic cont_q
);
   logic idle_ok;
   assign idle_ok = pipe_nak && !pipe_busy && !pipe_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbl_q  <= 1'b0;
         cont_q <= 1'b0;
      end else if (cfg_wr && idle_ok) begin
         dbl_q  <= dbl_req;
         cont_q <= cont_req;
      end
   end
endmodule

// File: rtl/usbp_side.sv
module usbp_side
   import usbp_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  usbp_side_ctl_s   ctl,
   input  logic [CNT_W-1:0] add,
   output logic [CNT_W-1:0] cnt,
   output logic             rdy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         rdy <= 1'b0;
      end else if (ctl.clr || ctl.drain_all) begin
         cnt <= '0;
         rdy <= 1'b0;
      end else if (ctl.drain_one) begin
         if (cnt <= CNT_W'(1)) begin
            cnt <= '0;
            rdy <= 1'b0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end else begin
         if (ctl.fill)  cnt <= cnt + add;
         if (ctl.close) rdy <= 1'b1;
      end
   end
endmodule

// File: rtl/usbp_done_eval.sv
module usbp_done_eval
   import usbp_pkg::*;
#(
   parameter int CNT_W = 9,
   parameter int LEN_W = 10,
   parameter int TRN_W = 4
) (
   input  logic             cont,
   input  usbp_dir_e        dir,
   input  logic [CNT_W-1:0] cap,
   input  logic [LEN_W-1:0] mps,
   input  logic [TRN_W-1:0] trn,
   input  logic [CNT_W-1:0] cnt,
   input  logic             rdy,
   input  logic [TRN_W-1:0] pkt_cnt,
   input  logic             rx_valid,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             cpu_wr,
   input  logic             cpu_bval,
   input  logic             cpu_dend,
   output logic             accept,
   output logic [CNT_W-1:0] fill_add,
   output logic             close,
   output logic             count_pkt
);
   localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

   logic [SUM_W-1:0] cap_x, mps_x, lim_x, rx_sum, wr_sum, cnt_x;
   logic [TRN_W:0]   pkt_next;
   logic             zlp_empty, trn_hit, short_pkt, rx_ok, wr_ok, cont_close;

   assign cnt_x    = SUM_W'(cnt);
   assign cap_x    = SUM_W'(cap);
   assign mps_x    = SUM_W'(mps);
   assign rx_sum   = cnt_x + SUM_W'(rx_len);
   assign wr_sum   = cnt_x + SUM_W'(1);
   assign lim_x    = (!cont && mps_x < cap_x) ? mps_x : cap_x;
   assign pkt_next = {1'b0, pkt_cnt} + (TRN_W+1)'(1);
   assign trn_hit  = (trn != '0) && (pkt_next == {1'b0, trn});

   assign zlp_empty  = cont && (rx_len == '0) && (cnt == '0);
   assign short_pkt  = (rx_len != '0) && (SUM_W'(rx_len) < mps_x);
   assign cont_close = (rx_sum == cap_x) || short_pkt ||
                       ((rx_len == '0) && (cnt != '0)) || trn_hit;
   assign rx_ok = rx_valid && !rdy && (rx_sum <= cap_x);
   assign wr_ok = cpu_wr && !rdy && (cnt_x < lim_x);

   always_comb begin
      accept    = 1'b0;
      fill_add  = '0;
      close     = 1'b0;
      count_pkt = 1'b0;
      if (dir == DIR_RX) begin
         accept    = rx_ok;
         fill_add  = CNT_W'(rx_len);
         close     = rx_ok && (!cont || (!zlp_empty && cont_close));
         count_pkt = rx_ok && cont && !zlp_empty;
      end else begin
         accept   = wr_ok;
         fill_add = CNT_W'(1);
         close    = !rdy && ((wr_ok && wr_sum == lim_x) || cpu_bval ||
                             (cont && wr_ok && cpu_dend));
      end
   end
endmodule

// File: rtl/usbp_pipe_buf.sv
module usbp_pipe_buf
   import usbp_pkg::*;
#(
   parameter int SIZE_W = 2,
   parameter int LEN_W  = 10,
   parameter int TRN_W  = 4,
   localparam int CNT_W = SIZE_W + 7,
   localparam int NSIDE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              cfg_dir,
   input  logic [LEN_W-1:0]  cfg_mps,
   input  logic [TRN_W-1:0]  cfg_trn,
   input  logic              cfg_wr,
   input  logic              cfg_dbl_req,
   input  logic              cfg_cont_req,
   input  logic              pipe_nak,
   input  logic              pipe_busy,
   input  logic              pipe_sel,
   input  logic              aclr,
   input  logic              cpu_wr,
   input  logic              cpu_bval,
   input  logic              cpu_dend,
   input  logic              cpu_rd,
   input  logic              rx_valid,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic              tx_sent,
   output logic              rx_ack,
   output logic              rdy_irq,
   output logic [1:0]        side_ready,
   output logic [CNT_W-1:0]  side_count0,
   output logic [CNT_W-1:0]  side_count1,
   output logic              usb_side,
   output logic              cpu_side,
   output logic              dbl_on,
   output logic              cont_on
);
   if (SIZE_W < 1 || SIZE_W > 8) begin : g_bad_size
      $error("usbp_pipe_buf: SIZE_W out of range");
   end
   if (LEN_W < 7) begin : g_bad_len
      $error("usbp_pipe_buf: LEN_W too small");
   end
   if (TRN_W < 1) begin : g_bad_trn
      $error("usbp_pipe_buf: TRN_W too small");
   end

   usbp_dir_e        dir;
   logic [CNT_W-1:0] cap;
   logic [CNT_W-1:0] side_cnt [NSIDE];
   logic [NSIDE-1:0] side_rdy;
   logic             usb_ptr, cpu_ptr, fill_side, drain_side;
   logic [TRN_W-1:0] pkt_cnt;
   logic             accept, close, count_pkt;
   logic             drain_one, drain_all, release_rx;
   logic [CNT_W-1:0] fill_add;

   assign dir = usbp_dir_e'(cfg_dir);
   assign cap = {({1'b0, cfg_size} + (SIZE_W+1)'(1)), 6'b0};

   assign fill_side  = (dir == DIR_TX) ? cpu_ptr : usb_ptr;
   assign drain_side = (dir == DIR_TX) ? usb_ptr : cpu_ptr;

   usbp_cfg_gate u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
      .dbl_req(cfg_dbl_req), .cont_req(cfg_cont_req),
      .pipe_nak(pipe_nak), .pipe_busy(pipe_busy), .pipe_sel(pipe_sel),
      .dbl_q(dbl_on), .cont_q(cont_on)
   );

   usbp_done_eval #(.CNT_W(CNT_W), .LEN_W(LEN_W), .TRN_W(TRN_W)) u_done (
      .cont(cont_on), .dir(dir), .cap(cap), .mps(cfg_mps), .trn(cfg_trn),
      .cnt(side_cnt[fill_side]), .rdy(side_rdy[fill_side]), .pkt_cnt(pkt_cnt),
      .rx_valid(rx_valid && !aclr), .rx_len(rx_len),
      .cpu_wr(cpu_wr && !aclr), .cpu_bval(cpu_bval && !aclr), .cpu_dend(cpu_dend),
      .accept(accept), .fill_add(fill_add), .close(close), .count_pkt(count_pkt)
   );

   assign drain_one  = (dir == DIR_RX) && cpu_rd && side_rdy[drain_side] && !aclr;
   assign drain_all  = (dir == DIR_TX) && tx_sent && side_rdy[drain_side] && !aclr;
   assign release_rx = drain_one && (side_cnt[drain_side] <= CNT_W'(1));

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      usbp_side_ctl_s ctl;
      assign ctl.clr       = aclr;
      assign ctl.fill      = accept    && (fill_side  == 1'(s));
      assign ctl.close     = close     && (fill_side  == 1'(s));
      assign ctl.drain_one = drain_one && (drain_side == 1'(s));
      assign ctl.drain_all = drain_all && (drain_side == 1'(s));
      usbp_side #(.CNT_W(CNT_W)) u_side (
         .clk(clk), .rst_n(rst_n), .ctl(ctl), .add(fill_add),
         .cnt(side_cnt[s]), .rdy(side_rdy[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usb_ptr <= 1'b0;
         cpu_ptr <= 1'b0;
         pkt_cnt <= '0;
         rdy_irq <= 1'b0;
         rx_ack  <= 1'b0;
      end else if (aclr) begin
         usb_ptr <= 1'b0;
         cpu_ptr <= 1'b0;
         pkt_cnt <= '0;
         rdy_irq <= 1'b0;
         rx_ack  <= 1'b0;
      end else begin
         if (dbl_on && ((dir == DIR_RX && close) || drain_all))
            usb_ptr <= !usb_ptr;
         if (dbl_on && ((dir == DIR_TX && close) || release_rx))
            cpu_ptr <= !cpu_ptr;
         if (close)          pkt_cnt <= '0;
         else if (count_pkt) pkt_cnt <= pkt_cnt + TRN_W'(1);
         rdy_irq <= close && !(dbl_on && dir == DIR_TX);
         rx_ack  <= (dir == DIR_RX) && accept;
      end
   end

   assign side_ready  = side_rdy;
   assign side_count0 = side_cnt[0];
   assign side_count1 = side_cnt[1];
   assign usb_side    = usb_ptr;
   assign cpu_side    = cpu_ptr;
endmodule

// File: rtl/usbp_pipe_buf_chk.sv
module usbp_pipe_buf_chk #(
   parameter int SIZE_W = 2,
   parameter int LEN_W  = 10,
   parameter int CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SIZE_W-1:0] cfg_size,
   input logic              cfg_dir,
   input logic              cfg_wr,
   input logic              pipe_nak,
   input logic              pipe_busy,
   input logic              pipe_sel,
   input logic              aclr,
   input logic              rx_valid,
   input logic [LEN_W-1:0]  rx_len,
   input logic              rx_ack,
   input logic              rdy_irq,
   input logic [1:0]        side_ready,
   input logic [CNT_W-1:0]  side_count0,
   input logic [CNT_W-1:0]  side_count1,
   input logic              usb_side,
   input logic              dbl_on,
   input logic              cont_on
);
   logic [CNT_W-1:0] cap_c, usb_cnt;
   assign cap_c   = CNT_W'((32'(cfg_size) + 1) * 64);
   assign usb_cnt = usb_side ? side_count1 : side_count0;

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_irq |-> !($past(dbl_on) && $past(cfg_dir)));

   assert_irq_has_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_irq |-> (side_ready != 2'b00));

   assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !(pipe_nak && !pipe_busy && !pipe_sel)) |=>
         ($stable(dbl_on) && $stable(cont_on)));

   assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      aclr |=> (side_ready == 2'b00 && side_count0 == '0 && side_count1 == '0));

   assert_zlp_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_len == '0 && cont_on && !cfg_dir && !aclr &&
       usb_cnt == '0 && !side_ready[usb_side]) |=> !rdy_irq);

   assert_pp_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cont_on && !cfg_dir && !aclr && !side_ready[usb_side] &&
       usb_cnt == '0 && CNT_W'(rx_len) <= cap_c && 32'(rx_len) <= 32'(cap_c)) |=>
         (rx_ack && rdy_irq));
endmodule

bind usbp_pipe_buf usbp_pipe_buf_chk #(.SIZE_W(SIZE_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_dir(cfg_dir),
   .cfg_wr(cfg_wr), .pipe_nak(pipe_nak), .pipe_busy(pipe_busy), .pipe_sel(pipe_sel),
   .aclr(aclr), .rx_valid(rx_valid), .rx_len(rx_len), .rx_ack(rx_ack),
   .rdy_irq(rdy_irq), .side_ready(side_ready), .side_count0(side_count0),
   .side_count1(side_count1), .usb_side(usb_side), .dbl_on(dbl_on), .cont_on(cont_on)
);

// File: tb/usbp_pipe_buf_test.sv
`timescale 1ns/1ps
module usbp_pipe_buf_test;
   localparam int SIZE_W = 2;
   localparam int LEN_W  = 10;
   localparam int TRN_W  = 4;
   localparam int CNT_W  = SIZE_W + 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SIZE_W-1:0] cfg_size = '0;
   logic cfg_dir = 1'b0;
   logic [LEN_W-1:0] cfg_mps = LEN_W'(64);
   logic [TRN_W-1:0] cfg_trn = '0;
   logic cfg_wr = 0, cfg_dbl_req = 0, cfg_cont_req = 0;
   logic pipe_nak = 1, pipe_busy = 0, pipe_sel = 0;
   logic aclr = 0, cpu_wr = 0, cpu_bval = 0, cpu_dend = 0, cpu_rd = 0;
   logic rx_valid = 0, tx_sent = 0;
   logic [LEN_W-1:0] rx_len = '0;
   logic rx_ack, rdy_irq, usb_side, cpu_side, dbl_on, cont_on;
   logic [1:0] side_ready;
   logic [CNT_W-1:0] side_count0, side_count1;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   usbp_pipe_buf #(.SIZE_W(SIZE_W), .LEN_W(LEN_W), .TRN_W(TRN_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_dir(cfg_dir),
      .cfg_mps(cfg_mps), .cfg_trn(cfg_trn), .cfg_wr(cfg_wr),
      .cfg_dbl_req(cfg_dbl_req), .cfg_cont_req(cfg_cont_req),
      .pipe_nak(pipe_nak), .pipe_busy(pipe_busy), .pipe_sel(pipe_sel),
      .aclr(aclr), .cpu_wr(cpu_wr), .cpu_bval(cpu_bval), .cpu_dend(cpu_dend),
      .cpu_rd(cpu_rd), .rx_valid(rx_valid), .rx_len(rx_len), .tx_sent(tx_sent),
      .rx_ack(rx_ack), .rdy_irq(rdy_irq), .side_ready(side_ready),
      .side_count0(side_count0), .side_count1(side_count1),
      .usb_side(usb_side), .cpu_side(cpu_side), .dbl_on(dbl_on), .cont_on(cont_on)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_buf();
      aclr = 1; tick(); aclr = 0;
   endtask

   task automatic set_cfg(input logic dbl, input logic cont);
      cfg_dbl_req = dbl; cfg_cont_req = cont; cfg_wr = 1;
      tick(); cfg_wr = 0;
   endtask

   task automatic rx(input int len);
      rx_valid = 1; rx_len = LEN_W'(len); tick(); rx_valid = 0;
   endtask

   task automatic wr(input logic dend);
      cpu_wr = 1; cpu_dend = dend; tick(); cpu_wr = 0; cpu_dend = 0;
   endtask

   task automatic wrn(input int n);
      for (int i = 0; i < n; i++) wr(1'b0);
   endtask

   task automatic bval();
      cpu_bval = 1; tick(); cpu_bval = 0;
   endtask

   task automatic rd();
      cpu_rd = 1; tick(); cpu_rd = 0;
   endtask

   task automatic send();
      tx_sent = 1; tick(); tx_sent = 0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      finish_run();
   end

   initial begin
      int caps[4];
      tick(); tick();
      rst_n = 1;
      tick();
      // reset state
      chk("R11 reset ready", side_ready, 0);
      chk("R11 reset count0", side_count0, 0);
      chk("R9 reset irq", rdy_irq, 0);
      chk("R10 reset dbl", dbl_on, 0);
      chk("R10 reset cont", cont_on, 0);

      // R1 / R2: per-packet receive over all sizes, boundaries
      cfg_dir = 0;
      set_cfg(0, 0);
      for (int sz = 0; sz < 4; sz++) begin
         int cap;
         cfg_size = SIZE_W'(sz);
         cap = (sz + 1) * 64;
         caps[0] = 0; caps[1] = 1; caps[2] = cap - 1; caps[3] = cap;
         for (int k = 0; k < 4; k++) begin
            clr_buf();
            rx(caps[k]);
            chk("R2 ack", rx_ack, 1);
            chk("R2 ready", side_ready, 1);
            chk("R2 count", side_count0, caps[k]);
            chk("R9 rx irq", rdy_irq, 1);
            rx(5);
            chk("R2 refuse when ready", rx_ack, 0);
            chk("R2 count kept", side_count0, caps[k]);
            for (int r = 0; r < ((caps[k] == 0) ? 1 : caps[k]); r++) rd();
            chk("R12 drained", side_ready, 0);
            chk("R12 drained count", side_count0, 0);
         end
         rx(cap + 1);
         chk("R1 oversize refused", rx_ack, 0);
         chk("R1 oversize no ready", side_ready, 0);
      end

      // R2 sweep of every length for size 0
      cfg_size = 0;
      for (int len = 0; len <= 64; len++) begin
         clr_buf();
         rx(len);
         chk("R2 sweep ready", side_ready, 1);
         chk("R2 sweep count", side_count0, len);
      end

      // R12 double buffered receive ping-pong
      clr_buf();
      set_cfg(1, 0);
      rx(10);
      chk("R12 side0 ready", side_ready, 1);
      chk("R12 usb moved", usb_side, 1);
      rx(20);
      chk("R12 both ready", side_ready, 3);
      chk("R12 side1 count", side_count1, 20);
      chk("R9 dbl rx irq", rdy_irq, 1);
      rx(3);
      chk("R12 third refused", rx_ack, 0);
      for (int r = 0; r < 9; r++) rd();
      chk("R12 partial read", side_count0, 1);
      rd();
      chk("R12 side0 free", side_ready, 2);
      chk("R12 cpu moved", cpu_side, 1);
      rx(3);
      chk("R12 refill side0", side_count0, 3);

      // R3 per-packet transmit
      cfg_dir = 1;
      clr_buf();
      set_cfg(0, 0);
      for (int m = 1; m <= 16; m++) begin
         clr_buf();
         cfg_mps = LEN_W'(m);
         wrn(m - 1);
         chk("R3 open below mps", side_ready, 0);
         chk("R3 count below mps", side_count0, m - 1);
         wr(0);
         chk("R3 closes at mps", side_ready, 1);
         chk("R3 count at mps", side_count0, m);
         chk("R9 tx irq", rdy_irq, 1);
         send();
         chk("R12 sent empties", side_ready, 0);
         chk("R12 sent count", side_count0, 0);
      end
      cfg_mps = LEN_W'(16);
      for (int n = 0; n <= 5; n++) begin
         clr_buf();
         wrn(n);
         bval();
         chk("R3 bval closes", side_ready, 1);
         chk("R3 bval count", side_count0, n);
      end
      clr_buf();
      wrn(2);
      wr(1);
      chk("R3 dend ignored", side_ready, 0);
      chk("R3 dend count", side_count0, 3);

      // R9 transmit with double buffering: no interrupt
      clr_buf();
      set_cfg(1, 0);
      cfg_mps = LEN_W'(4);
      wrn(4);
      chk("R9 side0 ready", side_ready, 1);
      chk("R9 masked irq", rdy_irq, 0);
      chk("R12 cpu moved tx", cpu_side, 1);
      wrn(4);
      chk("R9 both ready", side_ready, 3);
      wr(0);
      chk("R12 write dropped", side_count1, 4);
      send();
      chk("R12 send side0", side_ready, 2);
      chk("R12 usb moved tx", usb_side, 1);

      // R4-R7 continuous receive
      cfg_dir = 0;
      clr_buf();
      set_cfg(0, 1);
      cfg_mps = LEN_W'(16);
      for (int p = 1; p <= 3; p++) begin
         rx(16);
         chk("R4 open while not full", side_ready, 0);
         chk("R4 count", side_count0, 16 * p);
      end
      rx(16);
      chk("R4 full closes", side_ready, 1);
      chk("R4 full count", side_count0, 64);
      chk("R9 cont irq", rdy_irq, 1);
      for (int s = 1; s < 16; s++) begin
         clr_buf();
         rx(16);
         rx(s);
         chk("R5 short closes", side_ready, 1);
         chk("R5 short count", side_count0, 16 + s);
      end
      clr_buf();
      rx(0);
      chk("R6 zlp empty ack", rx_ack, 1);
      chk("R6 zlp empty no ready", side_ready, 0);
      chk("R6 zlp empty no irq", rdy_irq, 0);
      rx(16);
      rx(0);
      chk("R6 zlp closes", side_ready, 1);
      chk("R6 zlp count", side_count0, 16);
      clr_buf();
      cfg_trn = TRN_W'(1);
      rx(0);
      chk("R6 zlp not counted", side_ready, 0);
      cfg_mps = LEN_W'(8);
      for (int t = 1; t <= 5; t++) begin
         clr_buf();
         cfg_trn = TRN_W'(t);
         for (int p = 1; p < t; p++) rx(8);
         chk("R7 open before budget", side_ready, 0);
         rx(8);
         chk("R7 budget closes", side_ready, 1);
         chk("R7 budget count", side_count0, 8 * t);
      end
      cfg_trn = '0;

      // R8 continuous transmit
      cfg_dir = 1;
      cfg_mps = LEN_W'(16);
      clr_buf();
      wrn(63);
      chk("R8 open past mps", side_ready, 0);
      wr(0);
      chk("R8 full closes", side_ready, 1);
      chk("R8 full count", side_count0, 64);
      for (int n = 0; n <= 10; n++) begin
         clr_buf();
         wrn(n);
         bval();
         chk("R8 bval closes", side_ready, 1);
         chk("R8 bval count", side_count0, n);
         clr_buf();
         wrn(n);
         wr(1);
         chk("R8 dend closes", side_ready, 1);
         chk("R8 dend count", side_count0, n + 1);
      end

      // R10 configuration gate
      pipe_busy = 1; set_cfg(1, 0); pipe_busy = 0;
      chk("R10 busy dbl", dbl_on, 0);
      chk("R10 busy cont", cont_on, 1);
      pipe_sel = 1; set_cfg(1, 0); pipe_sel = 0;
      chk("R10 sel dbl", dbl_on, 0);
      pipe_nak = 0; set_cfg(1, 0); pipe_nak = 1;
      chk("R10 nak cont", cont_on, 1);
      set_cfg(1, 0);
      chk("R10 accepted dbl", dbl_on, 1);
      chk("R10 accepted cont", cont_on, 0);

      // R11 auto-clear
      cfg_dir = 0;
      clr_buf();
      rx(10);
      rx(12);
      chk("R11 pre-clear", side_ready, 3);
      clr_buf();
      chk("R11 ready cleared", side_ready, 0);
      chk("R11 count0 cleared", side_count0, 0);
      chk("R11 count1 cleared", side_count1, 0);
      chk("R11 usb ptr", usb_side, 0);
      chk("R11 cpu ptr", cpu_side, 0);

      finish_run();
   end
endmodule